// File: doc/BRIEF.md
# Multi-Channel Management Register File

This block is the management register space for a four-lane transceiver. Every access names a lane, a 5-bit register number, sixteen bits of write data, and a write or a read strobe. Each lane has its own 3-bit debug-mux selection, held in a test-control register. A single write can set the selection on one lane or on all lanes. Each lane also has a status register. In it, a signal-detect flag latches low, and two flags, one for a bad control word at the encoder and one for a bad code group at the decoder, latch high.

An extended space of sixteen 16-bit words is shared by the whole device and is reached indirectly. Register 30 holds the word index. Register 31 reads or writes the word that register 30 points at. Both registers return the same contents from every lane.

A read strobe captures the selected register into the read-data output at the clock edge. The value is therefore presented one cycle after the strobe. The same edge clears or reloads the status latches of the lane being read.

Top module: `mgmt_regfile`

## Requirements
- R1: After reset, register 27 reads 0x7000 on every lane, register 28 reads 0x0000 on every lane, registers 30 and 31 read 0x0000, all `test_sel` fields are 3'b111, and `rd_data` is 0x0000.
- R2: A read strobe loads `rd_data` at that clock edge with the addressed register's value from before the edge. While no read strobe is given, `rd_data` holds.
- R3: In register 27, bits 14:12 are the lane's mux selection. Bit 15 and bits 11:0 always read 0. Lane i's selection drives `test_sel[3i+2:3i]`.
- R4: A write to register 27 with bit 15 set loads bits 14:12 into the selection of all four lanes in the same cycle.
- R5: A write to register 27 with bit 15 clear changes only the addressed lane's selection.
- R6: Status bit 15 (signal detect) latches low. It reads 0 if its input was low at any clock edge since the lane's last status read. A status read reloads it with the live input.
- R7: Status bits 13 (encoder invalid) and 12 (decoder invalid) latch high. A status read clears them, but they stay set if the input is still high. All other status bits read 0.
- R8: A status read on one lane leaves the status latches of every other lane unchanged.
- R9: Register 30 is a 16-bit read/write register shared by the device. It reads the same value from any lane.
- R10: Register 31 reads and writes extended word number reg30[3:0]. The words are shared, so a word written from one lane reads back the same from any lane.
- R11: Writes to register 28 and to any register number other than 27, 30 and 31 have no effect. Register numbers other than 27, 28, 30 and 31 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_chan | input | 2 | Lane number of the access |
| acc_addr | input | 5 | Register number |
| acc_wdata | input | 16 | Write data |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe |
| rd_data | output | 16 | Read data, valid the cycle after a read strobe |
| sig_det_in | input | 4 | Live signal-detect per lane |
| enc_err_in | input | 4 | Encoder invalid-control-word event per lane |
| dec_err_in | input | 4 | Decoder invalid-code-group event per lane |
| test_sel | output | 12 | Debug-mux selection, 3 bits per lane |

## Verification
The mux selection is swept over every lane, every 3-bit value, and both settings of the broadcast bit, with junk in the low data bits. After each write, all four lanes are read back and compared with a bench model. This separates a broadcast write from a single-lane write and catches a selection that lands on the wrong lane.

The status latches are driven with single-cycle pulses and with held levels, and each case is read twice. The pulse case shows that an event is captured and then cleared by the read. The held case shows that a read does not clear a flag whose input is still active. Reading one lane between pulses on two lanes shows that the latches are independent per lane.

The extended window is filled by writing through rotating lanes and read back through a different lane. Every unmapped register number is written with all ones and read back.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 5;
    localparam int SEL_W   = 3;

    localparam logic [ADDR_W-1:0] REG_TEST  = 5'd27;
    localparam logic [ADDR_W-1:0] REG_STAT  = 5'd28;
    localparam logic [ADDR_W-1:0] REG_XADDR = 5'd30;
    localparam logic [ADDR_W-1:0] REG_XDATA = 5'd31;

    localparam int BCAST_BIT = 15;
    localparam int SEL_LSB   = 12;
    localparam int SD_BIT    = 15;
    localparam int ENC_BIT   = 13;
    localparam int DEC_BIT   = 12;

    localparam logic [SEL_W-1:0] SEL_RESET = '1;

    typedef struct packed {
        logic sd;
        logic enc;
        logic dec;
    } lane_stat_t;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_TEST,
        SRC_STAT,
        SRC_XADDR,
        SRC_XDATA
    } rd_src_e;

    function automatic rd_src_e decode_src(input logic [ADDR_W-1:0] a);
        case (a)
            REG_TEST:  return SRC_TEST;
            REG_STAT:  return SRC_STAT;
            REG_XADDR: return SRC_XADDR;
            REG_XDATA: return SRC_XDATA;
            default:   return SRC_NONE;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pack_test(input logic [SEL_W-1:0] sel);
        logic [DATA_W-1:0] w;
        w = '0;
        w[SEL_LSB +: SEL_W] = sel;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_status(input lane_stat_t s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[SD_BIT]  = s.sd;
        w[ENC_BIT] = s.enc;
        w[DEC_BIT] = s.dec;
        return w;
    endfunction

endpackage

// File: rtl/mgmt_test_ctrl.sv
module mgmt_test_ctrl
    import mgmt_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [CHW-1:0]             chan,
    input  logic                       bcast,
    input  logic [SEL_W-1:0]           sel_in,
    output logic [NCH-1:0][SEL_W-1:0]  sel
);

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        logic hit;
        assign hit = we && (bcast || (chan == CHW'(i)));
        always_ff @(posedge clk) begin
            if (rst) begin
                sel[i] <= SEL_RESET;
            end else if (hit) begin
                sel[i] <= sel_in;
            end
        end
    end

endmodule

// File: rtl/mgmt_status_latch.sv
module mgmt_status_latch
    import mgmt_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd_stb,
    input  logic [CHW-1:0]          rd_chan,
    input  logic [NCH-1:0]          sd_in,
    input  logic [NCH-1:0]          enc_in,
    input  logic [NCH-1:0]          dec_in,
    output lane_stat_t [NCH-1:0]    held
);

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        logic reload;
        assign reload = rd_stb && (rd_chan == CHW'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                held[i] <= '0;
            end else if (reload) begin
                held[i].sd  <= sd_in[i];
                held[i].enc <= enc_in[i];
                held[i].dec <= dec_in[i];
            end else begin
                held[i].sd  <= held[i].sd  & sd_in[i];
                held[i].enc <= held[i].enc | enc_in[i];
                held[i].dec <= held[i].dec | dec_in[i];
            end
        end
    end

endmodule

// File: rtl/mgmt_ext_window.sv
module mgmt_ext_window
    import mgmt_pkg::*;
#(
    parameter int IDX_W = 4,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_we,
    input  logic              data_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] xaddr,
    output logic [DATA_W-1:0] xdata
);

    logic [DEPTH-1:0][DATA_W-1:0] words;
    logic [IDX_W-1:0]             idx;

    assign idx   = xaddr[IDX_W-1:0];
    assign xdata = words[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            xaddr <= '0;
        end else if (addr_we) begin
            xaddr <= wdata;
        end
    end

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                words[w] <= '0;
            end else if (data_we && (idx == IDX_W'(w))) begin
                words[w] <= wdata;
            end
        end
    end

endmodule

// File: rtl/mgmt_regfile.sv
module mgmt_regfile
    import mgmt_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int IDX_W = 4,
    localparam int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [CHW-1:0]         acc_chan,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic [DATA_W-1:0]      acc_wdata,
    input  logic                   acc_wr,
    input  logic                   acc_rd,
    output logic [DATA_W-1:0]      rd_data,
    input  logic [NCH-1:0]         sig_det_in,
    input  logic [NCH-1:0]         enc_err_in,
    input  logic [NCH-1:0]         dec_err_in,
    output logic [NCH*SEL_W-1:0]   test_sel
);

    rd_src_e                    src;
    logic [NCH-1:0][SEL_W-1:0]  sel_q;
    lane_stat_t [NCH-1:0]       stat_q;
    logic [DATA_W-1:0]          xaddr_q;
    logic [DATA_W-1:0]          xdata_q;
    logic [DATA_W-1:0]          rd_mux;

    assign src      = decode_src(acc_addr);
    assign test_sel = sel_q;

    mgmt_test_ctrl #(.NCH(NCH)) u_test (
        .clk    (clk),
        .rst    (rst),
        .we     (acc_wr && (src == SRC_TEST)),
        .chan   (acc_chan),
        .bcast  (acc_wdata[BCAST_BIT]),
        .sel_in (acc_wdata[SEL_LSB +: SEL_W]),
        .sel    (sel_q)
    );

    mgmt_status_latch #(.NCH(NCH)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .rd_stb  (acc_rd && (src == SRC_STAT)),
        .rd_chan (acc_chan),
        .sd_in   (sig_det_in),
        .enc_in  (enc_err_in),
        .dec_in  (dec_err_in),
        .held    (stat_q)
    );

    mgmt_ext_window #(.IDX_W(IDX_W)) u_ext (
        .clk     (clk),
        .rst     (rst),
        .addr_we (acc_wr && (src == SRC_XADDR)),
        .data_we (acc_wr && (src == SRC_XDATA)),
        .wdata   (acc_wdata),
        .xaddr   (xaddr_q),
        .xdata   (xdata_q)
    );

    always_comb begin
        case (src)
            SRC_TEST:  rd_mux = pack_test(sel_q[acc_chan]);
            SRC_STAT:  rd_mux = pack_status(stat_q[acc_chan]);
            SRC_XADDR: rd_mux = xaddr_q;
            SRC_XDATA: rd_mux = xdata_q;
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (acc_rd) begin
            rd_data <= rd_mux;
        end
    end

endmodule

// File: rtl/mgmt_regfile_chk.sv
module mgmt_regfile_chk
    import mgmt_pkg::*;
#(
    parameter int NCH  = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic [CHW-1:0]        acc_chan,
    input logic [ADDR_W-1:0]     acc_addr,
    input logic [DATA_W-1:0]     acc_wdata,
    input logic                  acc_wr,
    input logic                  acc_rd,
    input logic [DATA_W-1:0]     rd_data,
    input logic [NCH-1:0]        sig_det_in,
    input logic [NCH-1:0]        enc_err_in,
    input logic [NCH-1:0]        dec_err_in,
    input logic [NCH*SEL_W-1:0]  test_sel
);

    assert_rd_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !acc_rd |=> $stable(rd_data));

    assert_test_zero_bits_R3: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && acc_addr == REG_TEST) |=> (rd_data[15] == 1'b0 && rd_data[11:0] == '0));

    assert_bcast_all_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && acc_addr == REG_TEST && acc_wdata[BCAST_BIT])
        |=> (test_sel == {NCH{$past(acc_wdata[SEL_LSB +: SEL_W])}}));

    assert_stat_zero_bits_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_rd && acc_addr == REG_STAT) |=> (rd_data[14] == 1'b0 && rd_data[11:0] == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_lane
        assert_single_lane_R5: assert property (@(posedge clk) disable iff (rst)
            (acc_wr && acc_addr == REG_TEST && !acc_wdata[BCAST_BIT] && acc_chan != CHW'(i))
            |=> $stable(test_sel[i*SEL_W +: SEL_W]));

        assert_sd_latch_low_R6: assert property (@(posedge clk) disable iff (rst)
            (acc_rd && acc_addr == REG_STAT && acc_chan == CHW'(i)
             && $past(!rst) && $past(!sig_det_in[i]))
            |=> (rd_data[SD_BIT] == 1'b0));

        assert_enc_latch_high_R7: assert property (@(posedge clk) disable iff (rst)
            (acc_rd && acc_addr == REG_STAT && acc_chan == CHW'(i)
             && $past(!rst) && $past(enc_err_in[i]))
            |=> (rd_data[ENC_BIT] == 1'b1));

        assert_dec_latch_high_R7: assert property (@(posedge clk) disable iff (rst)
            (acc_rd && acc_addr == REG_STAT && acc_chan == CHW'(i)
             && $past(!rst) && $past(dec_err_in[i]))
            |=> (rd_data[DEC_BIT] == 1'b1));
    end

endmodule

bind mgmt_regfile mgmt_regfile_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_chan   (acc_chan),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata),
    .acc_wr     (acc_wr),
    .acc_rd     (acc_rd),
    .rd_data    (rd_data),
    .sig_det_in (sig_det_in),
    .enc_err_in (enc_err_in),
    .dec_err_in (dec_err_in),
    .test_sel   (test_sel)
);

// File: tb/mgmt_regfile_test.sv
module mgmt_regfile_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  acc_chan = '0;
    logic [4:0]  acc_addr = '0;
    logic [15:0] acc_wdata = '0;
    logic        acc_wr = 1'b0;
    logic        acc_rd = 1'b0;
    logic [15:0] rd_data;
    logic [3:0]  sig_det_in = 4'hF;
    logic [3:0]  enc_err_in = '0;
    logic [3:0]  dec_err_in = '0;
    logic [11:0] test_sel;

    int n_cmp = 0;
    int n_bad = 0;
    logic [2:0] exp_sel [4];

    always #10 clk = ~clk;

    mgmt_regfile uut (
        .clk(clk), .rst(rst), .acc_chan(acc_chan), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_wr(acc_wr), .acc_rd(acc_rd),
        .rd_data(rd_data), .sig_det_in(sig_det_in), .enc_err_in(enc_err_in),
        .dec_err_in(dec_err_in), .test_sel(test_sel)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int a, input logic [15:0] d);
        @(negedge clk);
        acc_chan = 2'(ch); acc_addr = 5'(a); acc_wdata = d; acc_wr = 1'b1;
        @(negedge clk);
        acc_wr = 1'b0;
    endtask

    task automatic rd(input int ch, input int a, output logic [15:0] d);
        @(negedge clk);
        acc_chan = 2'(ch); acc_addr = 5'(a); acc_rd = 1'b1;
        @(negedge clk);
        acc_rd = 1'b0;
        d = rd_data;
    endtask

    function automatic logic [11:0] sel_vec();
        return {exp_sel[3], exp_sel[2], exp_sel[1], exp_sel[0]};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        check("R1 rd_data", rd_data, 16'h0000);
        check("R1 test_sel", {4'h0, test_sel}, 16'h0FFF);
        for (int c = 0; c < 4; c++) begin
            exp_sel[c] = 3'b111;
            rd(c, 27, v); check("R1 reg27", v, 16'h7000);
            rd(c, 28, v); check("R1 reg28", v, 16'h0000);
            rd(c, 30, v); check("R1 reg30", v, 16'h0000);
            rd(c, 31, v); check("R1 reg31", v, 16'h0000);
        end

        // R2 rd_data holds between reads
        rd(0, 27, v);
        repeat (3) @(negedge clk);
        check("R2 hold", rd_data, 16'h7000);

        // R3 R4 R5 sweep of lane, selection, broadcast
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 8; s++) begin
                for (int b = 0; b < 2; b++) begin
                    wr(c, 27, {b[0], s[2:0], 12'hA5C});
                    if (b == 1) for (int k = 0; k < 4; k++) exp_sel[k] = s[2:0];
                    else exp_sel[c] = s[2:0];
                    check(b == 1 ? "R4 test_sel" : "R5 test_sel", {4'h0, test_sel}, {4'h0, sel_vec()});
                    for (int k = 0; k < 4; k++) begin
                        rd(k, 27, v);
                        check("R3 reg27", v, {1'b0, exp_sel[k], 12'h000});
                    end
                end
            end
        end

        // R6 latch-low signal detect
        sig_det_in = 4'hF;
        for (int c = 0; c < 4; c++) rd(c, 28, v);
        rd(2, 28, v); check("R6 steady high", v, 16'h8000);
        @(negedge clk); sig_det_in[2] = 1'b0;
        @(negedge clk); sig_det_in[2] = 1'b1;
        rd(2, 28, v); check("R6 dropout latched", v, 16'h0000);
        rd(2, 28, v); check("R6 reload live", v, 16'h8000);
        @(negedge clk); sig_det_in[1] = 1'b0;
        rd(1, 28, v); check("R6 held low", v, 16'h0000);
        rd(1, 28, v); check("R6 still low", v, 16'h0000);
        sig_det_in[1] = 1'b1;
        rd(1, 28, v); rd(1, 28, v); check("R6 recovered", v, 16'h8000);

        // R7 latch-high error flags
        @(negedge clk); enc_err_in[0] = 1'b1;
        @(negedge clk); enc_err_in[0] = 1'b0;
        rd(0, 28, v); check("R7 enc pulse", v, 16'hA000);
        rd(0, 28, v); check("R7 enc cleared", v, 16'h8000);
        @(negedge clk); dec_err_in[3] = 1'b1;
        rd(3, 28, v); check("R7 dec held", v, 16'h9000);
        rd(3, 28, v); check("R7 dec still high", v, 16'h9000);
        dec_err_in[3] = 1'b0;
        rd(3, 28, v); rd(3, 28, v); check("R7 dec cleared", v, 16'h8000);

        // R8 per-lane independence
        @(negedge clk); enc_err_in[1] = 1'b1; dec_err_in[2] = 1'b1;
        @(negedge clk); enc_err_in[1] = 1'b0; dec_err_in[2] = 1'b0;
        rd(1, 28, v); check("R8 lane1", v, 16'hA000);
        rd(2, 28, v); check("R8 lane2 kept", v, 16'h9000);
        rd(1, 28, v); check("R8 lane1 cleared", v, 16'h8000);

        // R11 status writes ignored
        wr(0, 28, 16'h3000);
        rd(0, 28, v); check("R11 reg28 write", v, 16'h8000);

        // R9 R10 extended window
        for (int k = 0; k < 16; k++) begin
            wr(k % 4, 30, 16'hC000 + 16'(k));
            wr((k + 1) % 4, 31, (16'(k) * 16'h1111) ^ 16'h0F0F);
        end
        for (int k = 0; k < 16; k++) begin
            wr((k + 3) % 4, 30, 16'h4000 + 16'(k));
            for (int c = 0; c < 4; c++) begin
                rd(c, 30, v); check("R9 reg30", v, 16'h4000 + 16'(k));
            end
            rd((k + 2) % 4, 31, v);
            check("R10 reg31", v, (16'(k) * 16'h1111) ^ 16'h0F0F);
        end

        // R11 unmapped registers
        for (int a = 0; a < 32; a++) begin
            if (a < 27 || a == 29) begin
                wr(a % 4, a, 16'hFFFF);
                rd(a % 4, a, v); check("R11 unmapped read", v, 16'h0000);
            end
        end
        check("R11 test_sel kept", {4'h0, test_sel}, {4'h0, sel_vec()});
        wr(1, 30, 16'h0005);
        rd(0, 31, v); check("R11 ext kept", v, (16'd5 * 16'h1111) ^ 16'h0F0F);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule